// File: doc/BRIEF.md
# Pipelined Round-Key Generator with Selectable First Permutation

This block produces the sixteen 48-bit round keys of the 64-bit block cipher standard, one per round stage of a fully pipelined data path. A 64-bit key enters with each data block, together with a 2-bit choice of first permutation and a direction flag. The key state (two 28-bit halves) moves through sixteen registered stages in lockstep with the data. Stage r exposes the round key that data round r needs in the same cycle in which that block's data sits in round r. Because every stage holds its own copy of the key state, a fresh key, a fresh permutation choice and a fresh direction may be presented on every clock.

The first permutation drops the eight byte-parity bits and can be one of four 56-bit reorderings. Choice 0 is the standard one. Choices 1 to 3 are fixed reorderings of the standard output. The halves rotate left for encryption. For decryption they rotate right, with no rotation in the first stage, so that the round keys come out last-first. Each stage compresses its halves to 48 bits with the standard second permutation.

Top module: `ks_pipe`

## Requirements
- R1: The key bits at indices 0, 8, 16, 24, 32, 40, 48 and 56 of `key_in[63:0]` (the least significant bit of each byte, the parity bits) have no effect on any round key.
- R2: With `perm_sel` = 0 the standard first permutation is used; for key 0x133457799BBCDFF1 in encrypt mode the round keys 1, 2, 3 and 16 are 0x1B02EFFC7072, 0x79AED9DBC9E5, 0x55FC8A42CF99 and 0xCB3D8B0E17F5.
- R3: With `perm_sel` = 1, 2 or 3, output position j (0 = first) of the first permutation takes the bit that the standard permutation places at position 55-j, (j+28) mod 56 or 3j mod 56 respectively; every choice moves the 56 non-parity bits without loss.
- R4: In encrypt mode stage r rotates both halves left by one bit for r = 1, 2, 9, 16 and by two bits otherwise, so rotation keeps the number of ones in the key state.
- R5: Each stage forms its 48-bit round key from its two halves with the standard second permutation; an all-zero effective key gives all-zero round keys and an all-one effective key gives all-one round keys, for every `perm_sel`.
- R6: A key presented with `key_valid` high before rising edge k is visible on stage r (`stage_valid[r-1]` high, round key in `stage_subkey[48*r-1 -: 48]`) between edges k+r-1 and k+r.
- R7: A different key, permutation choice and direction may be presented on consecutive clocks; each travels down the stages without disturbing the others.
- R8: With `decrypt` high, stage r delivers the round key that encrypt mode delivers at stage 17-r, for every `perm_sel`.
- R9: While `rst_n` is low all `stage_valid` bits are 0, including when reset arrives in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | A key is presented this cycle |
| key_in | input | 64 | Key including parity bits |
| perm_sel | input | 2 | Choice of first permutation |
| decrypt | input | 1 | 1 = round keys in reverse order |
| stage_valid | output | 16 | Bit r-1 high when stage r holds a key |
| stage_subkey | output | 768 | Round key of stage r in bits 48*r-1 down to 48*(r-1) |

## Verification
The bench targets the parity positions by flipping all eight parity bits of a known key and by feeding keys made only of parity bits; a design that used a parity bit would change round key 1 or give non-zero keys. Known-answer round keys at stages 1, 2, 3 and 16 catch a wrong permutation table or a wrong rotation amount, since a single misplaced rotation corrupts every later stage. Decryption is checked both against the known keys and, for the three alternative permutations, by matching decrypt stage 16 with encrypt stage 1; a design that rotated in the first decrypt stage or rotated the wrong way would fail both. Back-to-back keys with mixed directions and a reset in mid-run catch stages that load out of step or keep stale valid bits.

// File: rtl/ks_pipe_pkg.sv
package ks_pipe_pkg;
  localparam int unsigned KEY_W    = 64;
  localparam int unsigned EFF_W    = 56;
  localparam int unsigned HALF_W   = EFF_W / 2;
  localparam int unsigned SUB_W    = 48;
  localparam int unsigned N_ROUNDS = 16;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned N_PERMS  = 1 << SEL_W;

  typedef logic [HALF_W-1:0] half_t;

  // Standard first permutation: source bit numbers, 1 = key MSB.
  localparam byte unsigned PC1_TAB [EFF_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  // Compression: source positions in the 56-bit state, 1 = MSB.
  localparam byte unsigned PC2_TAB [SUB_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  function automatic int unsigned rot_amount(int unsigned rnd);
    return (rnd == 1 || rnd == 2 || rnd == 9 || rnd == N_ROUNDS) ? 1 : 2;
  endfunction

  // Which position of the standard permutation feeds output j of choice sel.
  function automatic int unsigned alt_index(int unsigned sel, int unsigned j);
    case (sel)
      0:       return j;
      1:       return EFF_W - 1 - j;
      2:       return (j + HALF_W) % EFF_W;
      default: return (j * 3) % EFF_W;
    endcase
  endfunction

  function automatic half_t rotl(half_t h, int unsigned n);
    return (n == 0) ? h : half_t'((h << n) | (h >> (HALF_W - n)));
  endfunction

  function automatic half_t rotr(half_t h, int unsigned n);
    return (n == 0) ? h : half_t'((h >> n) | (h << (HALF_W - n)));
  endfunction
endpackage

// File: rtl/ks_first_perm.sv
module ks_first_perm
  import ks_pipe_pkg::*;
(
  input  logic [KEY_W-1:0] key,
  input  logic [SEL_W-1:0] sel,
  output half_t            c_half,
  output half_t            d_half
);
  localparam logic [KEY_W-1:0] NON_PARITY = {(KEY_W/8){8'hFE}};

  logic [EFF_W-1:0] cand [N_PERMS];
  logic [EFF_W-1:0] state;

  for (genvar v = 0; v < N_PERMS; v++) begin : g_perm
    for (genvar j = 0; j < EFF_W; j++) begin : g_bit
      assign cand[v][EFF_W-1-j] = key[KEY_W - PC1_TAB[alt_index(v, j)]];
    end
  end

  always_comb begin
    state = cand[sel];
    // R3 / R1: every choice keeps exactly the non-parity bits
    a_r3_no_bit_lost: assert ($countones(state) == $countones(key & NON_PARITY));
  end

  assign c_half = state[EFF_W-1:HALF_W];
  assign d_half = state[HALF_W-1:0];
endmodule

// File: rtl/ks_round_stage.sv
module ks_round_stage
  import ks_pipe_pkg::*;
#(
  parameter int unsigned RND = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_in,
  input  logic  dec_in,
  input  half_t c_in,
  input  half_t d_in,
  output logic  vld_q,
  output logic  dec_q,
  output half_t c_q,
  output half_t d_q
);
  localparam int unsigned ENC_ROT = rot_amount(RND);
  localparam int unsigned DEC_ROT = (RND == 1) ? 0 : rot_amount(N_ROUNDS + 2 - RND);

  half_t c_nxt, d_nxt;

  always_comb begin
    if (dec_in) begin
      c_nxt = rotr(c_in, DEC_ROT);
      d_nxt = rotr(d_in, DEC_ROT);
    end else begin
      c_nxt = rotl(c_in, ENC_ROT);
      d_nxt = rotl(d_in, ENC_ROT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_in;
  end

  always_ff @(posedge clk) begin
    if (vld_in) begin
      dec_q <= dec_in;
      c_q   <= c_nxt;
      d_q   <= d_nxt;
    end
  end

  // R4: rotation never changes the number of ones in the key state
  a_r4_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> ($countones({c_q, d_q}) == $countones($past({c_in, d_in}))));

  // R8: direction travels with the key
  a_r8_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> (dec_q == $past(dec_in)));
endmodule

// File: rtl/ks_compress.sv
module ks_compress
  import ks_pipe_pkg::*;
(
  input  half_t             c_half,
  input  half_t             d_half,
  output logic [SUB_W-1:0]  subkey
);
  logic [EFF_W-1:0] state;
  assign state = {c_half, d_half};

  for (genvar p = 0; p < SUB_W; p++) begin : g_bit
    assign subkey[SUB_W-1-p] = state[EFF_W - PC2_TAB[p]];
  end
endmodule

// File: rtl/ks_pipe.sv
module ks_pipe
  import ks_pipe_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_valid,
  input  logic [63:0]               key_in,
  input  logic [1:0]                perm_sel,
  input  logic                      decrypt,
  output logic [15:0]               stage_valid,
  output logic [16*48-1:0]          stage_subkey
);
  half_t c_h [N_ROUNDS+1];
  half_t d_h [N_ROUNDS+1];
  logic  vld [N_ROUNDS+1];
  logic  dec [N_ROUNDS+1];

  ks_first_perm u_first (
    .key    (key_in),
    .sel    (perm_sel),
    .c_half (c_h[0]),
    .d_half (d_h[0])
  );

  assign vld[0] = key_valid;
  assign dec[0] = decrypt;

  for (genvar r = 1; r <= N_ROUNDS; r++) begin : g_stage
    ks_round_stage #(.RND(r)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_in (vld[r-1]),
      .dec_in (dec[r-1]),
      .c_in   (c_h[r-1]),
      .d_in   (d_h[r-1]),
      .vld_q  (vld[r]),
      .dec_q  (dec[r]),
      .c_q    (c_h[r]),
      .d_q    (d_h[r])
    );

    ks_compress u_comp (
      .c_half (c_h[r]),
      .d_half (d_h[r]),
      .subkey (stage_subkey[SUB_W*r-1 -: SUB_W])
    );

    assign stage_valid[r-1] = vld[r];
  end

  // R6: one stage per clock, no gaps or stalls
  a_r6_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[0] == $past(key_valid));
  a_r6_valid_walk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[N_ROUNDS-1:1] == $past(stage_valid[N_ROUNDS-2:0]));
endmodule

// File: tb/ks_pipe_tb.sv
module ks_pipe_tb;
  logic          clk = 1'b0;
  logic          rst_n;
  logic          key_valid;
  logic [63:0]   key_in;
  logic [1:0]    perm_sel;
  logic          decrypt;
  logic [15:0]   stage_valid;
  logic [767:0]  stage_subkey;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ks_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_in(key_in),
    .perm_sel(perm_sel), .decrypt(decrypt),
    .stage_valid(stage_valid), .stage_subkey(stage_subkey)
  );

  localparam logic [63:0] KA   = 64'h133457799BBCDFF1;
  localparam logic [47:0] K1   = 48'h1B02EFFC7072;
  localparam logic [47:0] K2   = 48'h79AED9DBC9E5;
  localparam logic [47:0] K3   = 48'h55FC8A42CF99;
  localparam logic [47:0] K16  = 48'hCB3D8B0E17F5;
  localparam logic [47:0] ONES = 48'hFFFFFFFFFFFF;

  typedef struct packed {
    logic [63:0] key;
    logic [1:0]  sel;
    logic        dec;
    logic [4:0]  stg;
    logic [47:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{KA, 2'd0, 1'b0, 5'd1,  K1, 4'd2},                          // R2
    '{KA, 2'd0, 1'b0, 5'd2,  K2, 4'd4},                          // R4
    '{KA, 2'd0, 1'b0, 5'd3,  K3, 4'd4},                          // R4
    '{KA, 2'd0, 1'b0, 5'd16, K16, 4'd2},                         // R2
    '{KA ^ 64'h0101010101010101, 2'd0, 1'b0, 5'd1, K1, 4'd1},    // R1
    '{64'h0101010101010101, 2'd2, 1'b0, 5'd7, 48'h0, 4'd1},      // R1
    '{64'h0, 2'd3, 1'b0, 5'd5, 48'h0, 4'd5},                     // R5
    '{64'hFEFEFEFEFEFEFEFE, 2'd1, 1'b1, 5'd9, ONES, 4'd5},       // R5
    '{64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b0, 5'd12, ONES, 4'd5},      // R5
    '{KA, 2'd0, 1'b1, 5'd1,  K16, 4'd8},                         // R8
    '{KA, 2'd0, 1'b1, 5'd14, K3, 4'd8},                          // R8
    '{KA, 2'd0, 1'b1, 5'd15, K2, 4'd8},                          // R8
    '{KA, 2'd0, 1'b1, 5'd16, K1, 4'd8}                           // R8
  };

  function automatic logic [47:0] sk(int stg);
    return stage_subkey[48*stg-1 -: 48];
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one key for one clock; returns at the negedge after stage 1 loads
  task automatic push(logic [63:0] k, logic [1:0] s, logic d);
    @(negedge clk);
    key_valid = 1'b1; key_in = k; perm_sel = s; decrypt = d;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  logic [47:0] enc_s1 [4];

  initial begin
    rst_n = 1'b0; key_valid = 1'b0; key_in = '0; perm_sel = '0; decrypt = 1'b0;
    repeat (3) @(negedge clk);
    check(stage_valid == 16'h0, "R9 reset", {48'h0, stage_valid}, 64'h0);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      push(VECS[i].key, VECS[i].sel, VECS[i].dec);
      repeat (int'(VECS[i].stg) - 1) @(negedge clk);
      check(sk(int'(VECS[i].stg)) == VECS[i].exp,
            $sformatf("R%0d vec%0d", VECS[i].req, i),
            {16'h0, sk(int'(VECS[i].stg))}, {16'h0, VECS[i].exp});
      // R6: exactly this stage holds the key
      check(stage_valid == (16'h1 << (int'(VECS[i].stg) - 1)), "R6 position",
            {48'h0, stage_valid}, {48'h0, 16'h1 << (int'(VECS[i].stg) - 1)});
      repeat (17) @(negedge clk);
    end

    // R3: alternative choices differ from choice 0; R8 reverse order per choice
    for (int s = 1; s < 4; s++) begin
      push(KA, 2'(s), 1'b0);
      enc_s1[s] = sk(1);
      check(enc_s1[s] != K1, $sformatf("R3 choice %0d differs", s),
            {16'h0, enc_s1[s]}, {16'h0, K1});
      push(KA, 2'(s), 1'b1);
      repeat (15) @(negedge clk);
      check(sk(16) == enc_s1[s], $sformatf("R8 choice %0d reverse", s),
            {16'h0, sk(16)}, {16'h0, enc_s1[s]});
      repeat (2) @(negedge clk);
    end

    // R7: back-to-back keys with mixed direction and choice
    @(negedge clk);
    key_valid = 1'b1; key_in = KA; perm_sel = 2'd0; decrypt = 1'b0;
    @(negedge clk);
    key_in = 64'hFFFFFFFFFFFFFFFF; perm_sel = 2'd2; decrypt = 1'b1;
    @(negedge clk);
    key_in = KA ^ 64'h0101010101010101; perm_sel = 2'd0; decrypt = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    check(sk(3) == K3, "R7 stream oldest", {16'h0, sk(3)}, {16'h0, K3});
    check(sk(2) == ONES, "R7 stream middle", {16'h0, sk(2)}, {16'h0, ONES});
    check(sk(1) == K16, "R7 stream newest", {16'h0, sk(1)}, {16'h0, K16});
    check(stage_valid == 16'h0007, "R7 stream valid", {48'h0, stage_valid}, 64'h7);

    // R9: reset in the middle of a run
    @(negedge clk);
    check(stage_valid == 16'h000E, "R6 stream advance", {48'h0, stage_valid}, 64'hE);
    rst_n = 1'b0;
    #1;
    check(stage_valid == 16'h0, "R9 mid-run reset", {48'h0, stage_valid}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(stage_valid == 16'h0, "R9 stays idle", {48'h0, stage_valid}, 64'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule